// File: doc/BRIEF.md
# Floating-Point Status and Exception Register

This block is the control and status word of a floating-point unit. It holds the rounding mode handed to the arithmetic pipeline, a condition bit written by compare operations, five sticky exception flags, five trap enables and a set of per-operation cause bits. An arithmetic unit reports exceptions as a one-hot vector with a valid strobe. The block records each report in both the sticky flag and the cause field. It raises a one-cycle trap request when the reported class is enabled. An unimplemented-operation report always traps.

A strobe marks the start of every new arithmetic operation and wipes the cause field, so the cause bits only ever describe the most recent operation. Software reaches the register through a control-register port addressed by a 5-bit number. Register 31 is this status word. Every other number reads back a fixed implementation code, and writes to those numbers are dropped. The read port is registered.

Top module: `fp_status_reg`

## Requirements
- R1: After a synchronous reset the status word is 0, `trap_req` is 0 and `round_mode` is 0.
- R2: A report (`exc_valid` with `exc_onehot` bit k, where k=0 inexact, 1 underflow, 2 overflow, 3 divide-by-zero, 4 invalid) sets flag bit 2+k and cause bit 12+k. Other flag bits are unchanged.
- R3: Flag bits 6:2 are sticky. Start strobes and later reports never clear them. Only reset or a control write to register 31 can clear them.
- R4: `op_start` clears cause bits 17:12 in the same cycle. A report arriving in that cycle is recorded after the clear.
- R5: `trap_req` is high for exactly the cycle after a report of class k when enable bit 7+k is set. Without the enable, the flag and cause bits are still recorded and no trap is raised.
- R6: An unimplemented-operation report (`exc_onehot` bit 5) sets cause bit 17, leaves the flags untouched and always raises `trap_req` the next cycle.
- R7: `round_mode` shows status bits 1:0 (0 nearest, 1 toward zero, 2 toward +inf, 3 toward -inf), updated the cycle after a write.
- R8: `cmp_valid` loads `cmp_result` into condition bit 23 on the next edge.
- R9: A control write to register 31 stores the data masked to the implemented bits 1:0, 17:2 and 23, so the mask is 0x0083FFFF. Bits outside the mask read 0. A write to any other register number has no effect.
- R10: `ctl_rd_data` is registered. One cycle after `ctl_rd_addr` is presented, it returns the status word held at that edge for address 31, and 0x00000300 for any other address.
- R11: When a write to register 31 falls in the same cycle as a report or a compare, the write wins. The report and the compare are discarded, and no trap follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_start | input | 1 | New arithmetic operation; clears cause bits |
| exc_valid | input | 1 | Exception report strobe |
| exc_onehot | input | 6 | One-hot class: 0..4 IEEE classes, 5 unimplemented |
| cmp_valid | input | 1 | Compare result strobe |
| cmp_result | input | 1 | Value loaded into the condition bit |
| ctl_wr_en | input | 1 | Control register write strobe |
| ctl_wr_addr | input | 5 | Control register number for the write |
| ctl_wr_data | input | 32 | Write data |
| ctl_rd_addr | input | 5 | Control register number for the read |
| ctl_rd_data | output | 32 | Registered read data |
| round_mode | output | 2 | Current rounding mode |
| trap_req | output | 1 | One-cycle trap request |

## Verification
The two functions that can meet in one cycle are the control write and the exception report, and the compare port can join them. The bench drives a write to register 31 in the same cycle as an enabled invalid report and a compare. It then expects the written value alone in the next read and no trap pulse. It also pairs a start strobe with a report in one cycle, and expects only the new cause bit to survive while the older flags persist.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;
  localparam int NUM_CLS    = 5;
  localparam int REPORT_W   = NUM_CLS + 1;
  localparam int UNIMPL_IDX = NUM_CLS;
  localparam int RM_LSB     = 0;
  localparam int RM_W       = 2;
  localparam int FLAG_LSB   = 2;
  localparam int EN_LSB     = FLAG_LSB + NUM_CLS;
  localparam int CAUSE_LSB  = EN_LSB + NUM_CLS;
  localparam int UNIMPL_BIT = CAUSE_LSB + NUM_CLS;
  localparam int COND_BIT   = 23;
  localparam int STAT_W     = 32;

  typedef enum logic [2:0] {
    CLS_INEXACT  = 3'd0,
    CLS_UNDERFLW = 3'd1,
    CLS_OVERFLW  = 3'd2,
    CLS_DIVZERO  = 3'd3,
    CLS_INVALID  = 3'd4,
    CLS_UNIMPL   = 3'd5
  } exc_cls_e;

  function automatic logic [STAT_W-1:0] impl_mask();
    logic [STAT_W-1:0] m;
    m = '0;
    for (int i = RM_LSB; i <= UNIMPL_BIT; i++) m[i] = 1'b1;
    m[COND_BIT] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/fpsr_exc_unit.sv
module fpsr_exc_unit
  import fpsr_pkg::*;
(
  input  logic                op_start,
  input  logic                exc_valid,
  input  logic [REPORT_W-1:0] exc_onehot,
  input  logic [NUM_CLS-1:0]  cur_flags,
  input  logic [NUM_CLS-1:0]  cur_enables,
  input  logic [NUM_CLS:0]    cur_cause,
  output logic [NUM_CLS-1:0]  nxt_flags,
  output logic [NUM_CLS:0]    nxt_cause,
  output logic                trap_hit
);
  logic [REPORT_W-1:0] hit;
  logic [NUM_CLS:0]    cause_base;
  logic [NUM_CLS-1:0]  en_hit;

  assign hit        = exc_valid ? exc_onehot : '0;
  assign cause_base = op_start ? '0 : cur_cause;

  for (genvar k = 0; k < NUM_CLS; k++) begin : g_cls
    assign nxt_flags[k] = cur_flags[k] | hit[k];
    assign nxt_cause[k] = cause_base[k] | hit[k];
    assign en_hit[k]    = hit[k] & cur_enables[k];
  end

  assign nxt_cause[UNIMPL_IDX] = cause_base[UNIMPL_IDX] | hit[UNIMPL_IDX];
  assign trap_hit = hit[UNIMPL_IDX] | (|en_hit);
endmodule

// File: rtl/fpsr_rd_port.sv
module fpsr_rd_port #(
  parameter int          ADDR_W      = 5,
  parameter int          DATA_W      = 32,
  parameter int          STATUS_ADDR = 31,
  parameter logic [31:0] FIXED_VALUE = 32'h0000_0300
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] status,
  output logic [DATA_W-1:0] rd_data
);
  localparam logic [ADDR_W-1:0] SEL = ADDR_W'(STATUS_ADDR);

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_addr == SEL) rd_data <= status;
    else rd_data <= DATA_W'(FIXED_VALUE);
  end

  // R10: other addresses return the fixed code
  assert_rd_fixed_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rd_addr) != SEL) |-> rd_data == DATA_W'(FIXED_VALUE));
endmodule

// File: rtl/fp_status_reg.sv
module fp_status_reg
  import fpsr_pkg::*;
#(
  parameter int          ADDR_W      = 5,
  parameter int          STATUS_ADDR = 31,
  parameter logic [31:0] FIXED_VALUE = 32'h0000_0300
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                op_start,
  input  logic                exc_valid,
  input  logic [REPORT_W-1:0] exc_onehot,
  input  logic                cmp_valid,
  input  logic                cmp_result,
  input  logic                ctl_wr_en,
  input  logic [ADDR_W-1:0]   ctl_wr_addr,
  input  logic [STAT_W-1:0]   ctl_wr_data,
  input  logic [ADDR_W-1:0]   ctl_rd_addr,
  output logic [STAT_W-1:0]   ctl_rd_data,
  output logic [RM_W-1:0]     round_mode,
  output logic                trap_req
);
  localparam logic [STAT_W-1:0] MASK = impl_mask();
  localparam logic [ADDR_W-1:0] SEL  = ADDR_W'(STATUS_ADDR);

  logic [STAT_W-1:0]  status_q, status_d;
  logic [NUM_CLS-1:0] nxt_flags;
  logic [NUM_CLS:0]   nxt_cause;
  logic               trap_hit;
  logic               wr_hit;

  assign wr_hit = ctl_wr_en && (ctl_wr_addr == SEL);

  fpsr_exc_unit u_exc (
    .op_start    (op_start),
    .exc_valid   (exc_valid),
    .exc_onehot  (exc_onehot),
    .cur_flags   (status_q[FLAG_LSB +: NUM_CLS]),
    .cur_enables (status_q[EN_LSB +: NUM_CLS]),
    .cur_cause   (status_q[CAUSE_LSB +: NUM_CLS+1]),
    .nxt_flags   (nxt_flags),
    .nxt_cause   (nxt_cause),
    .trap_hit    (trap_hit)
  );

  always_comb begin
    status_d = status_q;
    status_d[FLAG_LSB +: NUM_CLS]    = nxt_flags;
    status_d[CAUSE_LSB +: NUM_CLS+1] = nxt_cause;
    if (cmp_valid) status_d[COND_BIT] = cmp_result;
    if (wr_hit) status_d = ctl_wr_data & MASK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q   <= '0;
      round_mode <= '0;
      trap_req   <= 1'b0;
    end else begin
      status_q   <= status_d;
      round_mode <= status_d[RM_LSB +: RM_W];
      trap_req   <= trap_hit && !wr_hit;
    end
  end

  fpsr_rd_port #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (STAT_W),
    .STATUS_ADDR (STATUS_ADDR),
    .FIXED_VALUE (FIXED_VALUE)
  ) u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd_addr (ctl_rd_addr),
    .status  (status_q),
    .rd_data (ctl_rd_data)
  );

  // R5 / R6: a trap is backed by a recorded cause that is enabled or unimplemented
  assert_trap_backed_R5: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> (status_q[UNIMPL_BIT] ||
                  |(status_q[CAUSE_LSB +: NUM_CLS] & status_q[EN_LSB +: NUM_CLS])));

  // R6: unimplemented report always traps
  assert_unimpl_trap_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(exc_valid && exc_onehot[UNIMPL_IDX] && !wr_hit)) |-> trap_req);

  // R3: flags never fall without a control write
  assert_flag_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_hit)) |->
      (($past(status_q[FLAG_LSB +: NUM_CLS]) & ~status_q[FLAG_LSB +: NUM_CLS]) == '0));

  // R4: a start strobe with no report leaves an empty cause field
  assert_cause_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_start && !exc_valid && !wr_hit)) |->
      status_q[CAUSE_LSB +: NUM_CLS+1] == '0);

  // R11: control write wins and suppresses the trap
  assert_wr_wins_R11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_hit)) |-> (status_q == $past(ctl_wr_data & MASK) && !trap_req));

  // R7: rounding mode follows a write
  assert_round_follow_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_hit)) |-> round_mode == $past(ctl_wr_data[RM_LSB +: RM_W]));
endmodule

// File: tb/fp_status_reg_tb.sv
module fp_status_reg_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_start = 0, exc_valid = 0, cmp_valid = 0, cmp_result = 0, ctl_wr_en = 0;
  logic [5:0]  exc_onehot = '0;
  logic [4:0]  ctl_wr_addr = '0, ctl_rd_addr = 5'd31;
  logic [31:0] ctl_wr_data = '0;
  logic [31:0] ctl_rd_data;
  logic [1:0]  round_mode;
  logic        trap_req;

  always #5 clk = ~clk;

  fp_status_reg dut_i (
    .clk(clk), .rst(rst), .op_start(op_start), .exc_valid(exc_valid),
    .exc_onehot(exc_onehot), .cmp_valid(cmp_valid), .cmp_result(cmp_result),
    .ctl_wr_en(ctl_wr_en), .ctl_wr_addr(ctl_wr_addr), .ctl_wr_data(ctl_wr_data),
    .ctl_rd_addr(ctl_rd_addr), .ctl_rd_data(ctl_rd_data),
    .round_mode(round_mode), .trap_req(trap_req)
  );

  typedef struct {
    logic [31:0] rd;
    logic        trap;
    logic [1:0]  rm;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  int          total = 0;
  int          bad = 0;
  bit          finished = 0;
  logic [31:0] model = '0;
  localparam logic [31:0] MASK_R9 = 32'h0083_FFFF;

  task automatic check(input logic [31:0] act, input logic [31:0] expv, input string what, input string tag);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  task automatic step(input logic op, input logic ev, input logic [5:0] vec,
                      input logic cv, input logic cr, input logic we,
                      input logic [4:0] wa, input logic [31:0] wd,
                      input logic [4:0] ra, input string tag);
    exp_t e;
    logic [31:0] nxt;
    logic        wr31, tr;
    @(negedge clk);
    op_start = op; exc_valid = ev; exc_onehot = vec; cmp_valid = cv; cmp_result = cr;
    ctl_wr_en = we; ctl_wr_addr = wa; ctl_wr_data = wd; ctl_rd_addr = ra;
    wr31 = we && (wa == 5'd31);
    nxt = model;
    if (op) nxt[17:12] = '0;
    tr = 1'b0;
    if (ev) begin
      for (int k = 0; k < 5; k++) if (vec[k]) begin
        nxt[2+k]  = 1'b1;
        nxt[12+k] = 1'b1;
        if (model[7+k]) tr = 1'b1;
      end
      if (vec[5]) begin nxt[17] = 1'b1; tr = 1'b1; end
    end
    if (cv) nxt[23] = cr;
    if (wr31) begin nxt = wd & MASK_R9; tr = 1'b0; end
    e.rd   = (ra == 5'd31) ? model : 32'h0000_0300;
    e.trap = tr;
    e.rm   = nxt[1:0];
    e.tag  = tag;
    model  = nxt;
    sb_q.push_back(e);
  endtask

  task automatic idle(input logic [4:0] ra, input string tag);
    step(0, 0, 6'b0, 0, 0, 0, 5'd0, 32'h0, ra, tag);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        e = sb_q.pop_front();
        check(ctl_rd_data, e.rd, "rd_data", e.tag);
        check({31'b0, trap_req}, {31'b0, e.trap}, "trap_req", e.tag);
        check({30'b0, round_mode}, {30'b0, e.rm}, "round_mode", e.tag);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin : watchdog
    #1000000;
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state seen on all outputs
    idle(5'd31, "R1");
    // R9: write all ones, masked; R7: rounding mode 3
    step(0, 0, 6'b0, 0, 0, 1, 5'd31, 32'hFFFF_FFFF, 5'd31, "R9_R7");
    idle(5'd31, "R9");
    step(0, 0, 6'b0, 0, 0, 1, 5'd31, 32'h0, 5'd31, "R9");
    // R9: other address write ignored; R10: fixed code read
    step(0, 0, 6'b0, 0, 0, 1, 5'd5, 32'hFFFF_FFFF, 5'd5, "R10");
    idle(5'd31, "R9");
    // R2 / R5: inexact, no enable, no trap
    step(1, 1, 6'b000001, 0, 0, 0, 5'd0, 32'h0, 5'd31, "R2_R5");
    // R4 / R3: start clears cause, flag stays
    step(1, 0, 6'b0, 0, 0, 0, 5'd0, 32'h0, 5'd31, "R4_R3");
    idle(5'd31, "R3");
    // R7: enable overflow, round toward zero
    step(0, 0, 6'b0, 0, 0, 1, 5'd31, 32'h0000_0201, 5'd31, "R7");
    // R5: enabled overflow traps
    step(1, 1, 6'b000100, 0, 0, 0, 5'd0, 32'h0, 5'd31, "R5");
    idle(5'd31, "R5");
    // R4 / R2: new op with underflow; old cause gone, flags accumulate
    step(1, 1, 6'b000010, 0, 0, 0, 5'd0, 32'h0, 5'd31, "R4_R2");
    idle(5'd31, "R3");
    // R6: unimplemented always traps, flags untouched
    step(1, 1, 6'b100000, 0, 0, 0, 5'd0, 32'h0, 5'd31, "R6");
    idle(5'd31, "R6");
    // R8: condition set and cleared
    step(0, 0, 6'b0, 1, 1, 0, 5'd0, 32'h0, 5'd31, "R8");
    idle(5'd31, "R8");
    step(0, 0, 6'b0, 1, 0, 0, 5'd0, 32'h0, 5'd31, "R8");
    idle(5'd31, "R8");
    // R11: enable invalid, then collide write with report and compare
    step(0, 0, 6'b0, 0, 0, 1, 5'd31, 32'h0000_0800, 5'd31, "R11");
    step(1, 1, 6'b010000, 1, 1, 1, 5'd31, 32'h0000_0002, 5'd31, "R11");
    idle(5'd31, "R11");
    // R9: report with a non-status write still lands
    step(1, 1, 6'b001000, 0, 0, 1, 5'd7, 32'h0000_0000, 5'd31, "R9_R2");
    idle(5'd31, "R9");
    idle(5'd12, "R10");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule